// File: doc/BRIEF.md
# Triggered Circular-Buffer Event Reader

This block sits behind one digitized detector channel. Every clock is a sampling clock. On each one the incoming sample is written into a circular dual-port buffer at the address given by a free-running, wrapping write counter. A trigger input, already synchronous to this clock, marks samples of interest. On each trigger the block stores the current write address as a timestamp in a small pending-trigger queue.

A push-mode readout engine empties the queue one entry at a time. It does not wait for a request from downstream. For each timestamp it steps back by a fixed latency to find where the event starts. It then streams a fixed-length block of consecutive samples out, framed by start and end markers.

Each trigger always gives its own event of the same length. Triggers that come close together therefore give events whose sample windows overlap, and the shared samples are sent again in each event. When the queue is full, a new trigger is dropped and a sticky overflow flag is set. The latency and window parameters, together with the buffer depth, must be chosen so that a window is fully written before it is read and is not overwritten while a queued trigger waits.

Top module: `trig_ring_reader`

## Requirements
- R1: While reset is held, `ev_valid`, `ev_first`, `ev_last` and `trig_ovf` are low.
- R2: On every clock edge after reset, `smp_in` is written into the buffer at the write counter's address, and the counter then advances by one. Counting starts at 0 and wraps modulo 2^AW.
- R3: An event caused by a trigger at the edge that writes sample S[t] carries, in order, samples S[t-LAT] to S[t-LAT+WIN-1].
- R4: Push mode. A trigger that arrives while the engine is idle with an empty queue gives its first word on `ev_data` two clock edges later. No downstream request is involved.
- R5: Each event is exactly WIN words, with `ev_valid` high on consecutive cycles. `ev_first` is high on the first word only and `ev_last` on the WIN-th word only. Both occur only together with `ev_valid`.
- R6: Every accepted trigger gives its own full-length event, in arrival order, even when windows overlap. Overlapping samples are sent again in each event.
- R7: The queue holds up to FD pending triggers. A trigger that arrives while FD entries are already queued (counted before any removal at that edge) is dropped. It then sets `trig_ovf`, which stays high until reset.
- R8: The latency subtraction and the address increment during readout both wrap modulo 2^AW, so events whose windows cross address 0 come out in the right order.
- R9: Between two events, `ev_valid` is low for exactly one cycle (the cycle in which the next entry is taken from the queue).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | DW | Sample written this clock |
| trig | input | 1 | Trigger, synchronous, at most one per clock |
| ev_data | output | DW | Event sample word |
| ev_valid | output | 1 | ev_data holds a word |
| ev_first | output | 1 | First word of an event |
| ev_last | output | 1 | Last (WIN-th) word of an event |
| trig_ovf | output | 1 | Sticky: a trigger was dropped because the queue was full |

## Verification
The assertions rely on the trigger being a single-clock pulse that is already aligned to the sampling clock. They also rely on the parameters keeping every queued window unread-free of overwrite. In other words, no trigger waits in the queue longer than the buffer depth minus LAT minus one cycle. The stimulus only fires triggers after more than LAT samples have been written, and it spaces them at least two cycles apart. Flooding stops once the queue has overflowed, so even the longest queued wait stays far inside the buffer depth. Isolated triggers, bursts of overlapping triggers and triggers whose windows cross the buffer's address 0 are all used.

// File: rtl/trig_ring_reader.sv
module trig_ring_reader #(
  parameter int DW  = 12,
  parameter int AW  = 8,
  parameter int LAT = 40,
  parameter int WIN = 32,
  parameter int FD  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_in,
  input  logic          trig,
  output logic [DW-1:0] ev_data,
  output logic          ev_valid,
  output logic          ev_first,
  output logic          ev_last,
  output logic          trig_ovf
);
  localparam int DEPTH = 1 << AW;
  localparam int FAW   = $clog2(FD);
  localparam int WCW   = $clog2(WIN);
  localparam logic [AW-1:0]  LAT_A = AW'(LAT);
  localparam logic [WCW-1:0] LASTW = WCW'(WIN - 1);
  localparam logic [FAW:0]   FULLC = (FAW+1)'(FD);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wptr, raddr;
  logic [AW-1:0]  fq [FD];
  logic [FAW-1:0] fwr, frd;
  logic [FAW:0]   fcnt;
  logic           busy;
  logic [WCW-1:0] wcnt;

  wire full = (fcnt == FULLC);
  wire push = trig && !full;
  wire pop  = !busy && (fcnt != '0);

  always_ff @(posedge clk) mem[wptr] <= smp_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wptr <= '0;
    else        wptr <= wptr + 1'b1;

  always_ff @(posedge clk) if (push) fq[fwr] <= wptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fwr      <= '0;
      frd      <= '0;
      fcnt     <= '0;
      trig_ovf <= 1'b0;
    end else begin
      if (push) fwr <= fwr + 1'b1;
      if (pop)  frd <= frd + 1'b1;
      fcnt <= fcnt + (FAW+1)'(push) - (FAW+1)'(pop);
      if (trig && full) trig_ovf <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      wcnt     <= '0;
      raddr    <= '0;
      ev_valid <= 1'b0;
      ev_first <= 1'b0;
      ev_last  <= 1'b0;
    end else begin
      ev_valid <= busy;
      ev_first <= busy && (wcnt == '0);
      ev_last  <= busy && (wcnt == LASTW);
      if (pop) begin
        raddr <= fq[frd] - LAT_A;
        wcnt  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        raddr <= raddr + 1'b1;
        wcnt  <= wcnt + 1'b1;
        if (wcnt == LASTW) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk) if (busy) ev_data <= mem[raddr];
endmodule

module trig_ring_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_valid,
  input logic ev_first,
  input logic ev_last,
  input logic trig_ovf
);
  // R5
  first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_first |-> ev_valid);
  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_last |-> ev_valid);
  // R5
  run_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_last) |=> (ev_valid && !ev_first));
  // R9
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_last |=> !ev_valid);
  // R5
  start_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (!ev_valid || ev_first));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) trig_ovf |=> trig_ovf);
endmodule

bind trig_ring_reader trig_ring_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_first(ev_first),
  .ev_last(ev_last), .trig_ovf(trig_ovf)
);

// File: tb/trig_ring_reader_test.sv
module trig_ring_reader_test;
  localparam int DW = 12, AW = 8, LAT = 40, WIN = 32, FD = 4;
  localparam int MAXC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] smp_in = '0;
  logic trig = 1'b0;
  logic [DW-1:0] ev_data;
  logic ev_valid, ev_first, ev_last, trig_ovf;

  trig_ring_reader #(.DW(DW), .AW(AW), .LAT(LAT), .WIN(WIN), .FD(FD)) uut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig(trig),
    .ev_data(ev_data), .ev_valid(ev_valid), .ev_first(ev_first),
    .ev_last(ev_last), .trig_ovf(trig_ovf)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int hist [MAXC];
  int n = 0;
  int q[$];
  int run_k = -1, cur = 0;
  bit exp_ovf = 1'b0;
  int accepted = 0, starts = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  task automatic step(bit t);
    int qsz;
    bit ev, ef, el;
    int ed;
    smp_in = DW'($urandom);
    trig = t;
    @(negedge clk);
    hist[n] = int'(smp_in);
    qsz = q.size();
    ev = 0; ef = 0; el = 0; ed = 0;
    if (run_k >= 0) begin
      ev = 1;
      ed = hist[cur - LAT + run_k];
      ef = (run_k == 0);
      el = (run_k == WIN - 1);
      run_k++;
      if (run_k == WIN) run_k = -1;
    end else if (qsz > 0) begin
      cur = q.pop_front();
      run_k = 0;
    end
    if (t) begin
      if (qsz >= FD) exp_ovf = 1'b1;
      else begin q.push_back(n); accepted++; end
    end
    chk(ev_valid == ev, "R4 R9 valid", int'(ev_valid), int'(ev));
    chk(ev_first == ef, "R5 first", int'(ev_first), int'(ef));
    chk(ev_last == el, "R5 last", int'(ev_last), int'(el));
    chk(trig_ovf == exp_ovf, "R7 overflow", int'(trig_ovf), int'(exp_ovf));
    if (ev) chk(int'(ev_data) == ed, "R2 R3 R8 data", int'(ev_data), ed);
    if (ev_valid && ev_first) starts++;
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ev_valid && !ev_first && !ev_last && !trig_ovf, "R1 reset state",
        int'({ev_valid, ev_first, ev_last, trig_ovf}), 0);
    rst_n = 1'b1;
    idle(100);
    // R4 single isolated trigger
    step(1'b1); idle(60);
    // R6 burst of three close triggers, overlapping windows
    step(1'b1); step(1'b0); step(1'b1); step(1'b0); step(1'b0); step(1'b1);
    idle(130);
    // R8 trigger whose window crosses address 0 (cycle near 256k + small)
    while ((n % 256) != 20) step(1'b0);
    step(1'b1); idle(60);
    // R6 medium spacing triggers
    for (int i = 0; i < 3; i++) begin step(1'b1); idle(9); end
    idle(120);
    // R7 flood until the queue overflows
    for (int i = 0; i < 8; i++) begin step(1'b1); step(1'b0); end
    idle(250);
    chk(trig_ovf == 1'b1, "R7 overflow sticky", int'(trig_ovf), 1);
    chk(starts == accepted, "R6 one event per accepted trigger", starts, accepted);
    // post-overflow traffic still read out
    step(1'b1); idle(80);
    chk(starts == accepted, "R6 events after overflow", starts, accepted);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ev_valid && !trig_ovf, "R1 reset clears", int'({ev_valid, trig_ovf}), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule